// File: doc/BRIEF.md
# Two-Tone FSK Bit Modulator

This block turns a slow serial bit stream, typically the transmit line of a UART, into a one-bit square-wave carrier for an external line driver. The carrier runs at one of two tone frequencies. The current level of the data line picks the tone. Both tones are made from a single fast master clock by a phase accumulator. Each clock, the accumulator adds a tuning word, and its most significant bit is the carrier. The tone frequency is therefore f_clk * word / 2^PHASE_W. Ratios that are not integers, such as a 12 MHz tone from a 32 MHz clock, need no divider.

The data line is asynchronous to the master clock, so it passes through a two-flop synchronizer before it chooses a tuning word. A bit change swaps only the word being added. The accumulator is never restarted, so the carrier phase stays continuous and no runt pulse appears at a tone change. There is no framing and no buffering: the tone follows the data line sample by sample. Taking enable low silences the output and clears the accumulator, so the next burst starts from phase zero.

Top module: `fskm_modulator`

## Requirements
- R1: While rst_ni is low, and after its release until the block has been enabled, tone_o is 0.
- R2: With data_i held at 1 (mark), the accumulator advances by mark_word_i every clock. Starting from a cleared state, tone_o shows floor((N*mark_word_i + 2^(PHASE_W-1)) / 2^PHASE_W) rising edges in N enabled clocks.
- R3: With data_i held at 0 (space), the accumulator advances by space_word_i every clock, and the same edge count applies with space_word_i.
- R4: tone_o is the accumulator MSB. Tuning words that do not divide 2^PHASE_W (for example 20000 or 7000 with PHASE_W=16) give the fractional edge counts of R2/R3.
- R5: data_i passes through a two-flop synchronizer. A change of data_i applied before clock edge k first changes the step added at edge k+2, so it can first move tone_o after edge k+2.
- R6: A change of data_i changes only the step. The accumulator keeps its value across the change, so the phase is continuous.
- R7: One clock edge after en_i is sampled low, tone_o is 0, and it stays 0 while en_i is low. The accumulator is then 0, so the first enabled edge leaves it equal to the selected word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable; low silences the output and clears the phase |
| data_i | input | 1 | Serial bit (1 = mark/higher tone, 0 = space/lower tone), asynchronous |
| mark_word_i | input | PHASE_W (16) | Tuning word used while the bit is 1 |
| space_word_i | input | PHASE_W (16) | Tuning word used while the bit is 0 |
| tone_o | output | 1 | Square-wave carrier, accumulator MSB |

## Verification
The accumulator and the carrier react to en_i and to the tuning words at the first rising edge after the inputs change. A change on data_i reaches the step only at the third edge, because it crosses both synchronizer flops first. The bench drives every input just after a falling edge and samples tone_o at the following falling edge. It runs an independent per-cycle model that delays the data bit by two edges, and compares tone_o with that model on every cycle. Directed tests count edges explicitly: the carrier stays put for two edges after a data change and moves on the third, and it is 0 one edge after enable drops.

// File: rtl/fskm_pkg.sv
package fskm_pkg;
  localparam int unsigned PHASE_W_DEF = 16;
  localparam int unsigned SYNC_DEF    = 2;
endpackage

// File: rtl/fskm_sync.sv
module fskm_sync #(
  parameter int unsigned STAGES = fskm_pkg::SYNC_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  output logic data_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], data_i};
  end

  assign data_o = chain_q[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk2
      AST_SYNC_RISE_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(data_o) |-> $past(data_i, 2)); // R5
      AST_SYNC_FALL_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(data_o) |-> !$past(data_i, 2)); // R5
    end
  endgenerate
endmodule

// File: rtl/fskm_phase_acc.sv
module fskm_phase_acc #(
  parameter int unsigned PHASE_W = fskm_pkg::PHASE_W_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [PHASE_W-1:0] step_i,
  output logic               msb_o
);
  localparam int unsigned MSB = PHASE_W - 1;

  logic [PHASE_W-1:0] acc_q;

  // wraps modulo 2^PHASE_W; never cleared on a step change
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (!en_i) acc_q <= '0;
    else            acc_q <= acc_q + step_i;
  end

  assign msb_o = acc_q[MSB];

  AST_ZERO_STEP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && step_i == '0) |=> $stable(acc_q)); // R6
  AST_RESTART_FROM_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!en_i) && en_i) |=> acc_q == $past(step_i)); // R7
endmodule

// File: rtl/fskm_modulator.sv
module fskm_modulator #(
  parameter int unsigned PHASE_W = fskm_pkg::PHASE_W_DEF,
  parameter int unsigned SYNC_N  = fskm_pkg::SYNC_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               data_i,
  input  logic [PHASE_W-1:0] mark_word_i,
  input  logic [PHASE_W-1:0] space_word_i,
  output logic               tone_o
);
  logic               bit_s;
  logic [PHASE_W-1:0] step;

  fskm_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .data_i(data_i),
    .data_o(bit_s)
  );

  assign step = bit_s ? mark_word_i : space_word_i;

  fskm_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .step_i(step),
    .msb_o (tone_o)
  );

  AST_OFF_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !tone_o); // R7
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> !tone_o); // R1
endmodule

// File: tb/fskm_modulator_bench.sv
module fskm_modulator_bench;
  localparam int W = 16;

  typedef struct packed {
    logic        d;
    logic        en;
    logic [15:0] mw;
    logic [15:0] sw;
    int          n;
    int          rises;
    int          req;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{d:1'b1, en:1'b1, mw:16'd24576, sw:16'd10240, n:64,  rises:24, req:2}, // R2 12/32 ratio
    '{d:1'b0, en:1'b1, mw:16'd24576, sw:16'd10240, n:64,  rises:10, req:3}, // R3 5/32 ratio
    '{d:1'b1, en:1'b1, mw:16'd20000, sw:16'd10240, n:100, rises:31, req:4}, // R4 fractional mark
    '{d:1'b0, en:1'b1, mw:16'd24576, sw:16'd7000,  n:100, rises:11, req:4}, // R4 fractional space
    '{d:1'b1, en:1'b0, mw:16'd24576, sw:16'd10240, n:64,  rises:0,  req:7}  // R7 disabled
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic dat = 1'b0;
  logic [W-1:0] mw = '0;
  logic [W-1:0] sw = '0;
  logic tone;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [W-1:0] m_acc = '0;
  logic m_s1 = 1'b0;
  logic m_s2 = 1'b0;

  always #2 clk = ~clk;

  fskm_modulator u_fskm_modulator (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .en_i        (en),
    .data_i      (dat),
    .mark_word_i (mw),
    .space_word_i(sw),
    .tone_o      (tone)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: tone_o=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: update reference model at the edge, compare at the next falling edge (R6)
  task automatic tick();
    @(posedge clk);
    if (!en) m_acc = '0;
    else     m_acc = m_acc + (m_s2 ? mw : sw);
    m_s2 = m_s1;
    m_s1 = dat;
    @(negedge clk);
    chk("R6 phase model", tone, m_acc[W-1]);
  endtask

  initial begin
    @(negedge clk);
    chk("R1 in reset", tone, 1'b0);
    repeat (3) @(negedge clk);
    chk("R1 in reset", tone, 1'b0);
    rst_n = 1'b1;
    dat = 1'b1;
    mw = 16'd24576;
    sw = 16'd10240;
    repeat (4) tick();
    chk("R1 after release, disabled", tone, 1'b0);

    foreach (VECS[i]) begin
      int cnt;
      logic prev;
      mw = VECS[i].mw;
      sw = VECS[i].sw;
      dat = VECS[i].d;
      en = 1'b0;
      repeat (3) tick();
      en = VECS[i].en;
      prev = tone;
      cnt = 0;
      for (int k = 0; k < VECS[i].n; k++) begin
        tick();
        if (tone && !prev) cnt++;
        prev = tone;
      end
      checks++;
      if (cnt != VECS[i].rises) begin
        errors++;
        $display("FAIL R%0d vec %0d: rises=%0d expected %0d", VECS[i].req, i, cnt, VECS[i].rises);
      end
    end

    // R5: synchronizer latency, data change first counts at third edge
    en = 1'b0; mw = 16'd0; sw = 16'd32768; dat = 1'b1;
    repeat (3) tick();
    en = 1'b1;
    repeat (3) tick();
    chk("R5 mark step zero", tone, 1'b0);
    dat = 1'b0;
    tick(); chk("R5 edge1 unchanged", tone, 1'b0);
    tick(); chk("R5 edge2 unchanged", tone, 1'b0);
    tick(); chk("R5 edge3 switched", tone, 1'b1);

    // R6: phase carries across the bit change
    en = 1'b0; mw = 16'd16384; sw = 16'd8192; dat = 1'b1;
    repeat (3) tick();
    en = 1'b1;
    tick(); tick();
    chk("R6 before change", tone, 1'b1);
    dat = 1'b0;
    tick(); chk("R6 old step edge1", tone, 1'b1);
    tick(); chk("R6 old step edge2 wraps", tone, 1'b0);
    tick(); tick(); tick();
    chk("R6 new step edge5", tone, 1'b0);
    tick();
    chk("R6 new step edge6", tone, 1'b1);

    // R7: disable clears, restart from zero
    en = 1'b0;
    tick(); chk("R7 silent after disable", tone, 1'b0);
    mw = 16'd32768; sw = 16'd32768;
    tick(); chk("R7 still silent", tone, 1'b0);
    en = 1'b1;
    tick(); chk("R7 restart equals word", tone, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, done=0 expected 1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule